// File: doc/BRIEF.md
# Serial Two-Wire Slave Front End with Rewritable Type Code

This block is the bus-facing part of a small register-based peripheral on a two-wire I2C-style bus. The block runs on a system clock. It oversamples the serial clock and data lines, detects START and STOP conditions, and collects the header byte that follows each START. That header holds a 4-bit device type code and a 3-bit strap address. When both match the block's own values, the block acknowledges the header. After that it passes received bytes to the register side, or fetches bytes from the register side and shifts them out.

The type code does not come from pins. It sits in a configuration register that resets to binary 0101, and the register side can overwrite it while the block is running. This lets more devices of the same kind share one bus. The block reports a commit pulse only when a STOP closes a write that carried data. The register side uses that pulse to start a nonvolatile update, so a write that ends in a repeated START never commits. The block only responds on the bus: it has no serial clock output and it pulls the data line low through an output-enable.

Top module: `busdev_i2c_slave`

## Requirements
- R1: A START (data falling while the clock is high) begins header reception from any state, including part-way through a byte. A following matching header is acknowledged.
- R2: The header is sent MSB first. Bits 7:4 hold the type code, bits 3:1 hold the strap address and bit 0 is the direction (1 = read, 0 = write).
- R3: The block pulls data low during the 9th clock only when the type code and the address both match. On a mismatch it keeps data released, and the bytes that follow give no rx_valid until the next START.
- R4: The type code is 0101 after reset. A one-cycle cfg_type_we loads cfg_type_val as the new type code, and after that the old code is no longer acknowledged.
- R5: Each write data byte is shifted in MSB first. It appears on rx_data with a one-cycle rx_valid pulse and is acknowledged on the 9th clock.
- R6: wr_commit pulses for one cycle when a STOP ends a write transfer that carried at least one data byte. A write ended by a repeated START, a header-only write and a read transfer give no pulse.
- R7: On a read, rd_take pulses for one cycle in the cycle the block captures tx_data. The byte is driven MSB first, and data changes only while the clock is low.
- R8: After each read byte the block releases data for the 9th clock. A master ACK (data low) loads the next byte. A NACK (data high) returns the block to idle with data released and no further byte taken.
- R9: While reset is active and after it is released, data is released and rx_valid, rd_take and wr_commit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_addr | input | 3 | Bus address from strap pins |
| cfg_type_we | input | 1 | Load a new type code |
| cfg_type_val | input | 4 | Type code value to load |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a written byte |
| rx_data | output | 8 | Last written data byte |
| tx_data | input | 8 | Byte to send, captured when rd_take pulses |
| rd_take | output | 1 | One-cycle pulse: tx_data captured |
| wr_commit | output | 1 | One-cycle pulse: STOP ended a write with data |

## Verification
The hardest case to reach from the ports is telling a STOP-ended write apart from one ended by a repeated START. Both deliver the same data bytes, and only the commit pulse differs. The stimulus writes a data byte and then issues a repeated START followed by a header that does not match. This closes the transfer without a STOP while rx_valid still shows the data arrived. A header-only write and a read closed by a STOP are added to cover the other no-commit cases. Aborting a header part-way through with a second START checks that the bit counter restarts cleanly.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } phase_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = d_i;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Edges of the clock line; conditions need the clock high on both samples
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [TW-1:0] my_type,
  input  logic [AW-1:0] my_addr,
  input  logic [DW-1:0] tx_data,
  output logic          sda_oe,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rd_take,
  output logic          wr_commit
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          rw_q, rw_d;
  logic          ackp_q, ackp_d;
  logic          nack_q, nack_d;
  logic          dirty_q, dirty_d;
  logic          oe_q, oe_d;
  logic          rxv_q, rxv_d;
  logic [DW-1:0] rxd_q, rxd_d;
  logic          take_q, take_d;
  logic          cmt_q, cmt_d;

  logic [DW-1:0] sh_in;
  logic          hdr_hit;

  assign sh_in   = {sh_q[DW-2:0], sda_lvl};
  assign hdr_hit = (sh_q[DW-2 -: TW] == my_type) && (sh_q[AW-1:0] == my_addr);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    ackp_d  = ackp_q;
    nack_d  = nack_q;
    dirty_d = dirty_q;
    oe_d    = oe_q;
    rxd_d   = rxd_q;
    rxv_d   = 1'b0;
    take_d  = 1'b0;
    cmt_d   = 1'b0;
    if (start_det) begin
      st_d    = ST_HDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      ackp_d  = 1'b0;
      dirty_d = 1'b0;
    end else if (stop_det) begin
      st_d    = ST_IDLE;
      oe_d    = 1'b0;
      ackp_d  = 1'b0;
      cmt_d   = dirty_q;
      dirty_d = 1'b0;
    end else begin
      case (st_q)
        ST_HDR: begin
          if (scl_rise) begin
            sh_d  = sh_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d = '0;
              if (hdr_hit) begin
                rw_d = sda_lvl;
                st_d = ST_HACK;
              end else begin
                st_d = ST_IDLE;
              end
            end
          end
        end
        ST_HACK, ST_WACK: begin
          if (scl_fall) begin
            if (!ackp_q) begin
              oe_d   = 1'b1;
              ackp_d = 1'b1;
            end else begin
              ackp_d = 1'b0;
              cnt_d  = '0;
              if (st_q == ST_HACK && rw_q) begin
                st_d   = ST_RDAT;
                sh_d   = tx_data;
                take_d = 1'b1;
                oe_d   = ~tx_data[DW-1];
              end else begin
                st_d = ST_WDAT;
                oe_d = 1'b0;
              end
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = sh_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d   = '0;
              rxv_d   = 1'b1;
              rxd_d   = sh_in;
              dirty_d = 1'b1;
              st_d    = ST_WACK;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            sh_d = {sh_q[DW-2:0], 1'b0};
            oe_d = ~sh_q[DW-2];
          end
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d = '0;
              st_d  = ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && ackp_q) nack_d = sda_lvl;
          if (scl_fall) begin
            if (!ackp_q) begin
              oe_d   = 1'b0;
              ackp_d = 1'b1;
            end else begin
              ackp_d = 1'b0;
              if (!nack_q) begin
                st_d   = ST_RDAT;
                sh_d   = tx_data;
                take_d = 1'b1;
                oe_d   = ~tx_data[DW-1];
              end else begin
                st_d = ST_IDLE;
                oe_d = 1'b0;
              end
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      ackp_q  <= 1'b0;
      nack_q  <= 1'b1;
      dirty_q <= 1'b0;
      oe_q    <= 1'b0;
      rxv_q   <= 1'b0;
      rxd_q   <= '0;
      take_q  <= 1'b0;
      cmt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      ackp_q  <= ackp_d;
      nack_q  <= nack_d;
      dirty_q <= dirty_d;
      oe_q    <= oe_d;
      rxv_q   <= rxv_d;
      rxd_q   <= rxd_d;
      take_q  <= take_d;
      cmt_q   <= cmt_d;
    end
  end

  assign sda_oe    = oe_q;
  assign rx_valid  = rxv_q;
  assign rx_data   = rxd_q;
  assign rd_take   = take_q;
  assign wr_commit = cmt_q;

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_det));

  // R5
  rx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(scl_rise));

  // R3
  hdr_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> !sda_oe);

  // R7
  oe_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl));

  // R8
  take_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> $past(scl_fall));
endmodule

// File: rtl/busdev_i2c_slave.sv
module busdev_i2c_slave #(
  parameter int               DATA_W      = 8,
  parameter int               TYPE_W      = 4,
  parameter int               ADDR_W      = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [TYPE_W-1:0] TYPE_RST   = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              cfg_type_we,
  input  logic [TYPE_W-1:0] cfg_type_val,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rd_take,
  output logic              wr_commit
);
  logic [1:0]        rst_q;
  logic              rst_int_n;
  logic [TYPE_W-1:0] type_q, type_d;
  logic [1:0]        line_s;
  logic              scl_rise, scl_fall, start_det, stop_det;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  always_comb begin
    type_d = type_q;
    if (cfg_type_we) type_d = cfg_type_val;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) type_q <= TYPE_RST;
    else            type_q <= type_d;
  end

  // R4
  type_load_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(type_q) |-> $past(cfg_type_we));

  i2cs_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2cs_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine #(.DW(DATA_W), .TW(TYPE_W), .AW(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_lvl   (line_s[1]),
    .sda_lvl   (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .my_type   (type_q),
    .my_addr   (strap_addr),
    .tx_data   (tx_data),
    .sda_oe    (sda_oe),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rd_take   (rd_take),
    .wr_commit (wr_commit)
  );
endmodule

// File: tb/busdev_i2c_slave_tb.sv
module busdev_i2c_slave_tb;
  localparam int Q = 6;

  logic       clk, rst_n;
  logic       m_scl, m_sda;
  logic [2:0] strap;
  logic       cfg_we;
  logic [3:0] cfg_val;
  logic [7:0] tx_data;
  logic       sda_oe, rx_valid, rd_take, wr_commit;
  logic [7:0] rx_data;
  logic       sda_bus;

  int nchk, nfail;
  int rx_cnt, cm_cnt, rd_cnt;
  logic [7:0] rx_last;

  assign sda_bus = m_sda & ~sda_oe;
  assign tx_data = 8'hC3 + 8'(rd_cnt * 17);

  busdev_i2c_slave u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (m_scl),
    .sda_i        (sda_bus),
    .sda_oe       (sda_oe),
    .strap_addr   (strap),
    .cfg_type_we  (cfg_we),
    .cfg_type_val (cfg_val),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .tx_data      (tx_data),
    .rd_take      (rd_take),
    .wr_commit    (wr_commit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt = 0; cm_cnt = 0; rd_cnt = 0; rx_last = 8'h00;
    end else begin
      if (rx_valid) begin rx_cnt = rx_cnt + 1; rx_last = rx_data; end
      if (wr_commit) cm_cnt = cm_cnt + 1;
      if (rd_take) rd_cnt = rd_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic m_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic m_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq; wq;
  endtask

  task automatic bit_w(input logic b);
    m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bit_r(output logic b);
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; b = sda_bus; wq; m_scl = 1'b0; wq;
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(nb);
    ack = ~nb;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); v[i] = b; end
    bit_w(~ack);
  endtask

  // {header, data, expected ack}; type 0101, strap 010
  localparam logic [16:0] VEC [7] = '{
    {8'h54, 8'h3C, 1'b1},
    {8'h54, 8'h81, 1'b1},
    {8'h5C, 8'h11, 1'b0},
    {8'h44, 8'h22, 1'b0},
    {8'hD4, 8'h33, 1'b0},
    {8'h54, 8'hFF, 1'b1},
    {8'h54, 8'h00, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic a, a2;
    logic [7:0] v;
    int rx0, cm0, rd0;
    nchk = 0; nfail = 0;
    m_scl = 1'b1; m_sda = 1'b1; strap = 3'b010; cfg_we = 1'b0; cfg_val = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9 during reset
    check("R9 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 line released", sda_bus, 1);
    check("R9 pulses low", {rx_valid, rd_take, wr_commit}, 0);

    // Vector table: R2 R3 R5 R6
    foreach (VEC[k]) begin
      rx0 = rx_cnt; cm0 = cm_cnt;
      m_start;
      wr_byte(VEC[k][16:9], a);
      check("R3 header ack", a, VEC[k][0]);
      wr_byte(VEC[k][8:1], a2);
      check("R5 data ack", a2, VEC[k][0]);
      m_stop;
      check("R5 rx count", rx_cnt - rx0, VEC[k][0]);
      if (VEC[k][0]) check("R5 rx byte", rx_last, VEC[k][8:1]);
      check("R6 commit on stop", cm_cnt - cm0, VEC[k][0]);
    end

    // R1: abort a header part-way, then a new START
    m_start;
    bit_w(1'b1); bit_w(1'b0); bit_w(1'b1); bit_w(1'b1);
    rx0 = rx_cnt; cm0 = cm_cnt;
    m_start;
    wr_byte(8'h54, a);
    check("R1 ack after restart", a, 1);
    wr_byte(8'h6B, a2);
    // R6: repeated START closes the write, no commit
    m_start;
    wr_byte(8'h5C, a);
    check("R3 mismatch nack", a, 0);
    m_stop;
    check("R5 rx before restart", rx_last, 8'h6B);
    check("R6 no commit after restart", cm_cnt - cm0, 0);

    // R6: header-only write
    cm0 = cm_cnt;
    m_start; wr_byte(8'h54, a); m_stop;
    check("R6 header-only no commit", cm_cnt - cm0, 0);

    // R4: new type code
    @(negedge clk); cfg_val = 4'b1010; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    m_start; wr_byte(8'h54, a); m_stop;
    check("R4 old type nack", a, 0);
    cm0 = cm_cnt;
    m_start; wr_byte(8'hA4, a); wr_byte(8'h5A, a2); m_stop;
    check("R4 new type ack", a, 1);
    check("R6 commit new type", cm_cnt - cm0, 1);

    // R7 R8: read two bytes, ACK then NACK
    rd0 = rd_cnt; cm0 = cm_cnt;
    m_start;
    wr_byte(8'hA5, a);
    check("R2 read header ack", a, 1);
    rd_byte(v, 1'b1);
    check("R7 first byte", v, 8'hC3);
    rd_byte(v, 1'b0);
    check("R7 second byte", v, 8'hD4);
    bit_r(a);
    check("R8 released after nack", a, 1);
    check("R8 bytes taken", rd_cnt - rd0, 2);
    m_stop;
    check("R6 read no commit", cm_cnt - cm0, 0);

    // R2: strap address change
    strap = 3'b111;
    m_start; wr_byte(8'hA4, a); m_stop;
    check("R2 old strap nack", a, 0);
    m_start; wr_byte(8'hAE, a); m_stop;
    check("R2 new strap ack", a, 1);

    // R4: reset restores 0101
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (5) @(negedge clk);
    strap = 3'b010;
    m_start; wr_byte(8'h54, a); m_stop;
    check("R4 reset type ack", a, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule